// File: doc/BRIEF.md
# Dual-Line Serial Packet Receiver

This block terminates a two-wire data link that shares one slow serial clock line. It samples the clock line and both data lines with a much faster local clock, behind a synchronizer, and finds packet boundaries from pulses on a data line while the clock line is held high. It then shifts 11-bit words in from the two lanes on each serial clock rising edge. The second lane runs a fixed number of serial clocks behind the first, and the two lanes carry alternate words, so the block merges them back into one word stream in packet order.

Each word carries an even parity bit in its top position, and the final word of a packet is the bitwise XOR of all words before it. The receiver checks both kinds of parity and also checks the packet length. Words leave on a valid-qualified stream with their packet index. The stream has no ready input because the link cannot be paused: the consumer must take each word in the one cycle its valid is high. Status pulses report the end of a packet, a bad column checksum and a framing or length fault.

Top module: `duo_lane_rx`

## Requirements
- R1: While reset is held and after it is released with idle lines, every output is low.
- R2: A packet begins when lane line A (`sd1_i`) shows four rising transitions during one high phase of `sclk_i`. The first data bit is sampled on the next `sclk_i` rising edge.
- R3: Data bits are sampled on `sclk_i` rising edges and change only while `sclk_i` is low. Each word is 11 bits, sent most significant bit first.
- R4: Lane A carries the words with indices 0, 2, 4, …. Lane B (`sd2_i`) carries indices 1, 3, 5, …, and its first bit is taken on the sixth `sclk_i` rising edge of the packet (lag of 5).
- R5: Words are emitted one per `word_valid_o` pulse in index order 0 to 261, each with its index on `word_idx_o`.
- R6: `word_par_err_o` is high together with a word exactly when that 11-bit word holds an odd number of ones.
- R7: When a packet of all 262 words is closed by a stop, `pkt_done_o` pulses. `sum_err_o` pulses with it when word 261 differs from the XOR of words 0 to 260.
- R8: A stop is four rising transitions on lane line B during one high phase of `sclk_i`. A stop outside a packet produces no output.
- R9: A stop that arrives before all 262 words have been received pulses `len_err_o` and gives no `pkt_done_o`.
- R10: After the last word, one further `sclk_i` rising edge (the one entering the stop) is allowed. A second one pulses `len_err_o` and returns the receiver to hunting for a start, so a later stop is ignored.
- R11: A start detected during a packet pulses `len_err_o` and begins a fresh packet.
- R12: Each output pulse is registered on the fourth local clock rising edge after the line transition that causes it is applied. It lasts one cycle.
- R13: There is no back-pressure. `word_valid_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock line |
| sd1_i | input | 1 | Lane A data line, also carries the start pattern |
| sd2_i | input | 1 | Lane B data line, also carries the stop pattern |
| word_valid_o | output | 1 | One-cycle strobe for a received word |
| word_data_o | output | 11 | Received word, parity bit in bit 10 |
| word_idx_o | output | 9 | Packet index of the word, 0 to 261 |
| word_par_err_o | output | 1 | Word parity fault, qualified by word_valid_o |
| pkt_done_o | output | 1 | A full-length packet was closed by a stop |
| sum_err_o | output | 1 | Column checksum mismatch, high only with pkt_done_o |
| len_err_o | output | 1 | Short packet, overrun, or restart inside a packet |

## Verification
Every result of this receiver is due on the fourth local clock edge after the line change that causes it: two synchronizer stages, one edge-detect stage and one output stage. The reference model in the bench works out the expected outputs in the same step that it drives the lines. It queues them, and then compares each queued entry four samples later, on the falling clock edge, against every output pin. The scenario totals of words, pulses and faults are counted from the same samples, so a word or a pulse that comes one cycle early or late is reported at that exact cycle.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;

  typedef enum logic {
    RX_HUNT = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;

  // Number of words a lane carries: lane 0 takes even indices, lane 1 odd.
  function automatic int lane_quota(input int total, input int lane);
    return (lane == 0) ? (total + 1) / 2 : total / 2;
  endfunction

endpackage

// File: rtl/dlrx_sync.sv
module dlrx_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o
);

  logic [LINES-1:0] chain [STAGES];
  logic [LINES-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      prev <= '0;
    end else begin
      chain[0] <= line_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev <= chain[STAGES-1];
    end
  end

  assign lvl_o  = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/dlrx_frame_det.sv
module dlrx_frame_det #(
  parameter int PULSES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_lvl_i,
  input  logic data_rise_i,
  output logic hit_o
);

  localparam int CNT_W = $clog2(PULSES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      hit_o <= 1'b0;
    end else begin
      hit_o <= 1'b0;
      if (!sclk_lvl_i) begin
        cnt <= '0;
      end else if (data_rise_i) begin
        if (cnt == CNT_W'(PULSES - 1)) begin
          hit_o <= 1'b1;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dlrx_lane.sv
module dlrx_lane #(
  parameter int WORD_W = 11,
  parameter int QUOTA  = 131
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);

  localparam int BIT_W = $clog2(WORD_W);
  localparam int CNT_W = $clog2(QUOTA + 1);

  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] sh_next;
  logic [BIT_W-1:0]  bcnt;
  logic [CNT_W-1:0]  wcnt;

  assign full_o  = (wcnt == CNT_W'(QUOTA));
  assign sh_next = {sh[WORD_W-2:0], bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      bcnt   <= '0;
      wcnt   <= '0;
      done_o <= 1'b0;
      word_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (clr_i) begin
        bcnt <= '0;
        wcnt <= '0;
      end else if (shift_i && !full_o) begin
        sh <= sh_next;
        if (bcnt == BIT_W'(WORD_W - 1)) begin
          bcnt   <= '0;
          wcnt   <= wcnt + 1'b1;
          done_o <= 1'b1;
          word_o <= sh_next;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/duo_lane_rx.sv
module duo_lane_rx
  import dlrx_pkg::*;
#(
  parameter int WORD_W       = 11,
  parameter int PKT_WORDS    = 262,
  parameter int LANE_LAG     = 5,
  parameter int FRAME_PULSES = 4,
  parameter int SYNC_STAGES  = 2,
  localparam int IDX_W       = $clog2(PKT_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sd1_i,
  input  logic              sd2_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic              word_par_err_o,
  output logic              pkt_done_o,
  output logic              sum_err_o,
  output logic              len_err_o
);

  localparam int LAG_W = $clog2(LANE_LAG + 2);
  localparam int NLANE = 2;

  // Synchronized lines: bit 0 serial clock, bit 1 lane A, bit 2 lane B.
  logic [2:0] lvl;
  logic [2:0] rise;

  dlrx_sync #(.LINES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i ({sd2_i, sd1_i, sclk_i}),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  // hit[0] = start seen on lane A, hit[1] = stop seen on lane B.
  logic [NLANE-1:0] hit;

  for (genvar g = 0; g < NLANE; g++) begin : g_frame
    dlrx_frame_det #(.PULSES(FRAME_PULSES)) u_det (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_lvl_i  (lvl[0]),
      .data_rise_i (rise[g+1]),
      .hit_o       (hit[g])
    );
  end

  rx_state_e         state;
  logic              run;
  logic              sclk_rise;
  logic [LAG_W-1:0]  lag_cnt;
  logic              extra_seen;
  logic              ovr_q;
  logic [NLANE-1:0]  shift;
  logic [NLANE-1:0]  done_q;
  logic [NLANE-1:0]  full;
  logic [WORD_W-1:0] lane_word [NLANE];
  logic              all_full;

  assign run       = (state == RX_RUN);
  assign sclk_rise = rise[0];
  assign all_full  = &full;
  assign shift[0]  = run && sclk_rise;
  assign shift[1]  = run && sclk_rise && (lag_cnt == LAG_W'(LANE_LAG));

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    dlrx_lane #(.WORD_W(WORD_W), .QUOTA(lane_quota(PKT_WORDS, g))) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (hit[0]),
      .shift_i (shift[g]),
      .bit_i   (lvl[g+1]),
      .done_o  (done_q[g]),
      .word_o  (lane_word[g]),
      .full_o  (full[g])
    );
  end

  // Lane B start delay and overrun watch, same stage as the lanes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lag_cnt    <= '0;
      extra_seen <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      ovr_q <= 1'b0;
      if (hit[0]) begin
        lag_cnt    <= '0;
        extra_seen <= 1'b0;
      end else if (run && sclk_rise) begin
        if (lag_cnt != LAG_W'(LANE_LAG)) lag_cnt <= lag_cnt + 1'b1;
        if (all_full) begin
          if (extra_seen) ovr_q <= 1'b1;
          else            extra_seen <= 1'b1;
        end
      end
    end
  end

  // In-order merge of the two lanes.
  logic [IDX_W-1:0]  next_idx;
  logic              exp_lane;
  logic              use_pend;
  logic              emit;
  logic [WORD_W-1:0] emit_data;
  logic [NLANE-1:0]  pend;
  logic [WORD_W-1:0] hold [NLANE];
  logic [WORD_W-1:0] col_acc;
  logic              sum_bad;

  always_comb begin
    exp_lane  = next_idx[0];
    use_pend  = pend[exp_lane];
    emit      = run && (next_idx < IDX_W'(PKT_WORDS)) && (pend[exp_lane] || done_q[exp_lane]);
    emit_data = use_pend ? hold[exp_lane] : lane_word[exp_lane];
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_hold
    logic take;
    assign take = emit && (exp_lane == 1'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[g] <= 1'b0;
        hold[g] <= '0;
      end else if (hit[0]) begin
        pend[g] <= 1'b0;
      end else if (take && use_pend) begin
        pend[g] <= done_q[g];
        if (done_q[g]) hold[g] <= lane_word[g];
      end else if (done_q[g] && !take) begin
        pend[g] <= 1'b1;
        hold[g] <= lane_word[g];
      end
    end
  end

  // Packet control and registered outputs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= RX_HUNT;
      next_idx       <= '0;
      col_acc        <= '0;
      sum_bad        <= 1'b0;
      word_valid_o   <= 1'b0;
      word_data_o    <= '0;
      word_idx_o     <= '0;
      word_par_err_o <= 1'b0;
      pkt_done_o     <= 1'b0;
      sum_err_o      <= 1'b0;
      len_err_o      <= 1'b0;
    end else begin
      word_valid_o   <= 1'b0;
      word_par_err_o <= 1'b0;
      pkt_done_o     <= 1'b0;
      sum_err_o      <= 1'b0;
      len_err_o      <= 1'b0;
      if (hit[0]) begin
        len_err_o <= run;
        state     <= RX_RUN;
        next_idx  <= '0;
        col_acc   <= '0;
        sum_bad   <= 1'b0;
      end else if (hit[1] && run) begin
        state <= RX_HUNT;
        if (all_full) begin
          pkt_done_o <= 1'b1;
          sum_err_o  <= sum_bad;
        end else begin
          len_err_o <= 1'b1;
        end
      end else if (ovr_q) begin
        state     <= RX_HUNT;
        len_err_o <= 1'b1;
      end else if (emit) begin
        word_valid_o   <= 1'b1;
        word_data_o    <= emit_data;
        word_idx_o     <= next_idx;
        word_par_err_o <= ^emit_data;
        next_idx       <= next_idx + 1'b1;
        if (next_idx == IDX_W'(PKT_WORDS - 1)) sum_bad <= (emit_data != col_acc);
        else                                   col_acc <= col_acc ^ emit_data;
      end
    end
  end

endmodule

// File: rtl/dlrx_chk.sv
module dlrx_chk #(
  parameter int WORD_W    = 11,
  parameter int PKT_WORDS = 262,
  parameter int IDX_W     = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_valid_o,
  input logic [WORD_W-1:0] word_data_o,
  input logic [IDX_W-1:0]  word_idx_o,
  input logic              word_par_err_o,
  input logic              pkt_done_o,
  input logic              sum_err_o,
  input logic              len_err_o
);

  logic [IDX_W-1:0] last_idx;
  logic             got_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx <= '0;
      got_last <= 1'b0;
    end else begin
      if (word_valid_o) last_idx <= word_idx_o;
      if (pkt_done_o || len_err_o || (word_valid_o && word_idx_o == '0))
        got_last <= 1'b0;
      else if (word_valid_o && word_idx_o == IDX_W'(PKT_WORDS - 1))
        got_last <= 1'b1;
    end
  end

  a_r5_idx_order: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && word_idx_o != '0) |-> (word_idx_o == last_idx + 1'b1));

  a_r6_perr_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    word_par_err_o |-> word_valid_o);

  a_r7_sum_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    sum_err_o |-> pkt_done_o);

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done_o |-> got_last);

  a_r9_done_len_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_done_o, len_err_o}));

  a_r13_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  a_r5_data_known: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> !$isunknown(word_data_o));

endmodule

bind duo_lane_rx dlrx_chk #(
  .WORD_W    (WORD_W),
  .PKT_WORDS (PKT_WORDS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .word_valid_o   (word_valid_o),
  .word_data_o    (word_data_o),
  .word_idx_o     (word_idx_o),
  .word_par_err_o (word_par_err_o),
  .pkt_done_o     (pkt_done_o),
  .sum_err_o      (sum_err_o),
  .len_err_o      (len_err_o)
);

// File: tb/duo_lane_rx_tb.sv
module duo_lane_rx_tb;

  localparam int N   = 262;
  localparam int W   = 11;
  localparam int LAG = 5;
  localparam int Q0  = (N + 1) / 2;
  localparam int Q1  = N / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, sda = 1'b0, sdb = 1'b0;
  logic        vld, perr, done, serr, lerr;
  logic [W-1:0] dat;
  logic [8:0]  idx;

  always #10 clk = ~clk;

  duo_lane_rx u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sd1_i(sda), .sd2_i(sdb),
    .word_valid_o(vld), .word_data_o(dat), .word_idx_o(idx),
    .word_par_err_o(perr), .pkt_done_o(done), .sum_err_o(serr), .len_err_o(lerr)
  );

  typedef struct {
    logic v; logic [W-1:0] d; int i; logic pe, dn, se, le;
  } ev_t;

  ev_t exp_q[$];
  int  checks = 0, failures = 0;
  bit  finished = 0;

  // observed totals
  int o_words, o_done, o_serr, o_perr, o_lerr, o_b2b;
  logic o_prev_v;
  logic [W-1:0] o_first, o_last;

  // reference model state
  logic pc = 0, pa = 0, pb = 0;
  int   m_c0 = 0, m_c1 = 0, m_r = 0, extra = 0;
  bit   m_run = 0, sumbad = 0;
  int   m_w[2], m_b[2];
  logic [W-1:0] m_sh[2];
  logic [W-1:0] acc;

  logic [W-1:0] pkt [N];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic clear_obs();
    o_words = 0; o_done = 0; o_serr = 0; o_perr = 0; o_lerr = 0; o_b2b = 0;
    o_first = '0; o_last = '0;
  endtask

  task automatic compare();
    ev_t e;
    e = exp_q.pop_front();
    chk(vld == e.v, "R5 R12", "valid", int'(vld), int'(e.v));
    if (e.v && vld) begin
      chk(dat == e.d, "R3 R4", "data", int'(dat), int'(e.d));
      chk(int'(idx) == e.i, "R5", "index", int'(idx), e.i);
      chk(perr == e.pe, "R6", "parity flag", int'(perr), int'(e.pe));
    end
    chk(done == e.dn, "R7 R8", "done", int'(done), int'(e.dn));
    chk(serr == e.se, "R7", "sum error", int'(serr), int'(e.se));
    chk(lerr == e.le, "R9 R10 R11", "length error", int'(lerr), int'(e.le));
    if (vld) begin
      if (idx == 0) o_first = dat;
      if (int'(idx) == N - 1) o_last = dat;
      o_words++;
      if (o_prev_v) o_b2b++;
    end
    o_prev_v = vld;
    if (perr && vld) o_perr++;
    if (done) o_done++;
    if (serr) o_serr++;
    if (lerr) o_lerr++;
  endtask

  function automatic void lane_reset();
    m_r = 0; extra = 0; acc = '0; sumbad = 0;
    for (int l = 0; l < 2; l++) begin m_w[l] = 0; m_b[l] = 0; m_sh[l] = '0; end
  endfunction

  function automatic void emit(ref ev_t e, input int id, input logic [W-1:0] d);
    e.v = 1; e.d = d; e.i = id; e.pe = ^d;
    if (id == N - 1) sumbad = (d != acc);
    else acc = acc ^ d;
  endfunction

  function automatic ev_t model(input logic c, input logic a, input logic b);
    ev_t e;
    bit rc, ra, rb, st, sp;
    e = '{v:0, d:'0, i:0, pe:0, dn:0, se:0, le:0};
    rc = c && !pc; ra = a && !pa; rb = b && !pb;
    st = 0; sp = 0;
    if (!c) begin
      m_c0 = 0; m_c1 = 0;
    end else begin
      if (ra) begin if (m_c0 == 3) begin st = 1; m_c0 = 0; end else m_c0++; end
      if (rb) begin if (m_c1 == 3) begin sp = 1; m_c1 = 0; end else m_c1++; end
    end
    if (st) begin
      if (m_run) e.le = 1;
      m_run = 1;
      lane_reset();
    end else if (sp) begin
      if (m_run) begin
        m_run = 0;
        if (m_w[0] == Q0 && m_w[1] == Q1) begin e.dn = 1; e.se = sumbad; end
        else e.le = 1;
      end
    end else if (rc && m_run) begin
      if (m_w[0] == Q0 && m_w[1] == Q1) begin
        if (extra != 0) begin e.le = 1; m_run = 0; end
        else extra = 1;
      end else begin
        if (m_w[0] < Q0) begin
          m_sh[0] = {m_sh[0][W-2:0], a}; m_b[0]++;
          if (m_b[0] == W) begin emit(e, 2 * m_w[0], m_sh[0]); m_b[0] = 0; m_w[0]++; end
        end
        if (m_r >= LAG && m_w[1] < Q1) begin
          m_sh[1] = {m_sh[1][W-2:0], b}; m_b[1]++;
          if (m_b[1] == W) begin emit(e, 2 * m_w[1] + 1, m_sh[1]); m_b[1] = 0; m_w[1]++; end
        end
        m_r++;
      end
    end
    pc = c; pa = a; pb = b;
    return e;
  endfunction

  task automatic step(input logic c, input logic a, input logic b);
    @(negedge clk);
    compare();
    sclk = c; sda = a; sdb = b;
    exp_q.push_back(model(c, a, b));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(sclk, sda, sdb);
  endtask

  task automatic send_rise(input logic a, input logic b);
    step(0, sda, sdb);
    step(0, a, b);
    step(1, a, b);
    step(1, a, b);
  endtask

  task automatic start_seq();
    step(0, 0, 0);
    step(1, 0, 0);
    for (int k = 0; k < 4; k++) begin step(1, 1, 0); step(1, 0, 0); end
    step(0, 0, 0);
  endtask

  task automatic stop_seq();
    step(0, 0, 0);
    step(1, 0, 0);
    for (int k = 0; k < 4; k++) begin step(1, 0, 1); step(1, 0, 0); end
    step(0, 0, 0);
  endtask

  task automatic send_words(input int m);
    int rises, ra, rb;
    ra = W * ((m + 1) / 2);
    rb = (m >= 2) ? LAG + W * (m / 2) : 0;
    rises = (ra > rb) ? ra : rb;
    for (int r = 1; r <= rises; r++) begin
      logic a, b;
      int id;
      a = 0; b = 0;
      id = 2 * ((r - 1) / W);
      if (id < m) a = pkt[id][W - 1 - (r - 1) % W];
      if (r > LAG) begin
        id = 2 * ((r - LAG - 1) / W) + 1;
        if (id < m) b = pkt[id][W - 1 - (r - LAG - 1) % W];
      end
      send_rise(a, b);
    end
  endtask

  task automatic make_packet(input bit bad);
    logic [W-1:0] s;
    s = '0;
    for (int k = 0; k < N - 1; k++) begin
      logic [W-2:0] p;
      p = W'($urandom) & {(W-1){1'b1}};
      pkt[k] = {^p, p};
      s = s ^ pkt[k];
    end
    pkt[N-1] = s;
    if (bad) pkt[7][3] = ~pkt[7][3];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    o_prev_v = 0;
    clear_obs();
    repeat (5) @(negedge clk);
    chk(!vld && !perr && !done && !serr && !lerr, "R1", "outputs in reset",
        int'({vld, perr, done, serr, lerr}), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) exp_q.push_back('{v:0, d:'0, i:0, pe:0, dn:0, se:0, le:0});
    idle(6);
    chk(!vld && !done && !lerr, "R1", "outputs after reset", int'({vld, done, lerr}), 0);

    // good packet
    clear_obs();
    make_packet(0);
    start_seq(); send_words(N); stop_seq(); idle(8);
    chk(o_words == N, "R5", "word count", o_words, N);
    chk(o_first == pkt[0], "R2 R3", "first word", int'(o_first), int'(pkt[0]));
    chk(o_last == pkt[N-1], "R4", "last word", int'(o_last), int'(pkt[N-1]));
    chk(o_done == 1 && o_serr == 0, "R7", "clean done", o_done * 10 + o_serr, 10);
    chk(o_perr == 0 && o_lerr == 0, "R6", "no faults", o_perr + o_lerr, 0);
    chk(o_b2b == 0, "R13", "adjacent strobes", o_b2b, 0);

    // stop while hunting
    clear_obs();
    stop_seq(); idle(8);
    chk(o_words + o_done + o_lerr == 0, "R8", "stop while idle", o_words + o_done + o_lerr, 0);

    // corrupted packet
    clear_obs();
    make_packet(1);
    start_seq(); send_words(N); stop_seq(); idle(8);
    chk(o_perr == 1, "R6", "parity faults", o_perr, 1);
    chk(o_done == 1 && o_serr == 1, "R7", "checksum fault", o_done * 10 + o_serr, 11);

    // short packet
    clear_obs();
    make_packet(0);
    start_seq(); send_words(10); stop_seq(); idle(8);
    chk(o_lerr == 1 && o_done == 0, "R9", "short packet", o_lerr * 10 + o_done, 10);
    chk(o_words == 10, "R9", "short word count", o_words, 10);

    // overrun then ignored stop
    clear_obs();
    start_seq(); send_words(N); send_rise(0, 0); send_rise(0, 0); idle(8);
    chk(o_lerr == 1, "R10", "overrun", o_lerr, 1);
    stop_seq(); idle(8);
    chk(o_done == 0 && o_lerr == 1, "R10", "stop after overrun", o_done * 10 + o_lerr, 1);

    // restart inside a packet
    clear_obs();
    start_seq(); send_words(20); start_seq(); send_words(N); stop_seq(); idle(8);
    chk(o_lerr == 1 && o_done == 1, "R11", "restart", o_lerr * 10 + o_done, 11);
    chk(o_words == 20 + N, "R11", "restart word count", o_words, 20 + N);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule